// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures how fast one clock runs, compared with a reference clock. A select input picks one of several candidate clocks. While the run input is high, that clock passes through a gate into a small counter that runs in the measured clock's own domain. The counter counts only rising edges.

After a start, the block first holds off for a fixed settling period of reference cycles, during which no edge is counted. It then opens a counting window that lasts a programmed number of reference cycles. When the window closes, the Gray-coded edge count crosses into the reference domain through two flops. The block captures the count and then raises a done flag. Software divides the count by the window length to get the frequency ratio. The count saturates, and a sticky flag records an overflow. A new measurement needs run to go low and then high again.

Top module: `clk_freq_meter`

## Requirements
- R1: While reset is held, `count` is 0, `overflow` is 0 and `done` is 0.
- R2: For the selected source `src_clks[i]` with period Ts and a window of W reference cycles of period Tr, the reported count N satisfies |N·Ts − W·Tr| ≤ Ts. Only rising edges of the source are counted.
- R3: If the edge total would exceed 2^CNT_W − 1, `count` stays at all ones and `overflow` reads 1 for that measurement.
- R4: No source edge is counted during the SETTLE_CYC (default 24) reference cycles that follow a start. A window length of 0 reports `count` = 0 with `done` = 1.
- R5: `done` rises no earlier than SETTLE_CYC + W reference cycles after run is first seen high. `count` and `overflow` hold steady while `done` is high.
- R6: When run goes low, `done` is 0 after the next reference edge. The first reference edge of a new start clears `count` and `overflow` to 0.
- R7: `src_sel` is sampled on the reference edge at which run is first seen high. Changes to `src_sel` while run stays high do not affect the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the settle and window periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clks | input | NUM_SRC | Candidate clocks to be measured |
| src_sel | input | SEL_W | Index of the clock to measure |
| run | input | 1 | Starts a measurement when it goes high; aborts or clears when low |
| win_len | input | WIN_W | Window length in reference cycles |
| count | output | CNT_W | Saturating rising-edge count of the last measurement |
| overflow | output | 1 | The count saturated during the last measurement |
| done | output | 1 | The result is valid |

## Verification
The bench runs source-to-reference ratios that are not whole numbers, so a fixed phase cannot hide an off-by-one. A design that counted both edges, or that took its window length from the wrong register, would fall outside the ±1 band. A zero-length window exposes any counting during the settling period: a leaky design reports roughly 24 times the ratio instead of 0. A narrow second instance, with a 10-bit count, must pin at all ones with the overflow flag set and then come back clean on the next run; a design that wraps or keeps the flag would show a small count or a stale flag. The bench also changes the select in the middle of a measurement, which catches a design that follows the live select instead of the one sampled at start.

// File: rtl/clk_freq_meter.sv
`timescale 1ns/100ps
module clk_freq_meter #(
  parameter int NUM_SRC    = 4,
  parameter int SEL_W      = $clog2(NUM_SRC),
  parameter int CNT_W      = 20,
  parameter int WIN_W      = 16,
  parameter int SETTLE_CYC = 24,
  parameter int DRAIN_CYC  = 3
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               run,
  input  logic [WIN_W-1:0]   win_len,
  output logic [CNT_W-1:0]   count,
  output logic               overflow,
  output logic               done
);
  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_WIN, S_DRAIN, S_DONE} st_t;

  st_t             st;
  logic [WIN_W-1:0] tmr;
  logic [SEL_W-1:0] sel_q;
  logic             seen;
  logic             gate_on, win_en, gclk, mrst_n;

  assign gate_on = (st != S_IDLE);
  assign win_en  = (st == S_WIN);
  assign gclk    = src_clks[sel_q] & gate_on;
  assign mrst_n  = rst_n & gate_on;

  // measured-clock domain
  logic             en_m1, en_m2, ovf_m, ovf_nxt;
  logic [CNT_W-1:0] bin_m, bin_nxt, gray_m;

  always_comb begin
    bin_nxt = bin_m;
    ovf_nxt = ovf_m;
    if (en_m2) begin
      if (&bin_m) ovf_nxt = 1'b1;
      else        bin_nxt = bin_m + CNT_W'(1);
    end
  end

  always_ff @(posedge gclk or negedge mrst_n) begin
    if (!mrst_n) begin
      en_m1  <= 1'b0;
      en_m2  <= 1'b0;
      bin_m  <= '0;
      gray_m <= '0;
      ovf_m  <= 1'b0;
    end else begin
      en_m1  <= win_en;
      en_m2  <= en_m1;
      bin_m  <= bin_nxt;
      gray_m <= bin_nxt ^ (bin_nxt >> 1);
      ovf_m  <= ovf_nxt;
    end
  end

  // reference domain
  logic [CNT_W-1:0] gray_s1, gray_s2, bin_r;
  logic             ovf_s1, ovf_s2, ack_s1, ack_s2;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_s1 <= '0; gray_s2 <= '0;
      ovf_s1  <= 1'b0; ovf_s2 <= 1'b0;
      ack_s1  <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      gray_s1 <= gray_m; gray_s2 <= gray_s1;
      ovf_s1  <= ovf_m;  ovf_s2  <= ovf_s1;
      ack_s1  <= en_m2;  ack_s2  <= ack_s1;
    end
  end

  always_comb
    for (int i = 0; i < CNT_W; i++) bin_r[i] = ^(gray_s2 >> i);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      sel_q    <= '0;
      seen     <= 1'b0;
      count    <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
    end else if (!run) begin
      st   <= S_IDLE;
      seen <= 1'b0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          sel_q    <= src_sel;
          tmr      <= WIN_W'(SETTLE_CYC - 1);
          count    <= '0;
          overflow <= 1'b0;
          st       <= S_SETTLE;
        end
        S_SETTLE:
          if (tmr == '0) begin
            if (win_len == '0) begin
              seen <= 1'b1;
              tmr  <= WIN_W'(DRAIN_CYC);
              st   <= S_DRAIN;
            end else begin
              tmr <= win_len - WIN_W'(1);
              st  <= S_WIN;
            end
          end else tmr <= tmr - WIN_W'(1);
        S_WIN: begin
          if (ack_s2) seen <= 1'b1;
          if (tmr == '0) begin
            tmr <= WIN_W'(DRAIN_CYC);
            st  <= S_DRAIN;
          end else tmr <= tmr - WIN_W'(1);
        end
        S_DRAIN: begin
          if (ack_s2) seen <= 1'b1;
          if (seen && !ack_s2) begin
            if (tmr == '0) begin
              count    <= bin_r;
              overflow <= ovf_s2;
              st       <= S_DONE;
            end else tmr <= tmr - WIN_W'(1);
          end
        end
        S_DONE:  done <= 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sat_full_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    overflow |-> (&count));

  assert_settle_quiet_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> !ack_s2);

  assert_result_hold_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(count) && $stable(overflow)));

  assert_stop_clears_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !run |=> !done);

  assert_sel_frozen_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (gate_on && $past(gate_on)) |-> $stable(sel_q));
endmodule

// File: tb/clk_freq_meter_tb_top.sv
`timescale 1ns/100ps
module clk_freq_meter_tb_top;
  localparam real TCLK = 10.0;
  localparam int  TREF = 100;                        // reference period in 100 ps units
  localparam int  PER [4] = '{40, 70, 130, 250};     // source periods in 100 ps units
  localparam int  NV = 7;
  localparam logic [17:0] VECS [NV] = '{
    {2'd0, 16'd100}, {2'd1, 16'd100}, {2'd2, 16'd200}, {2'd3, 16'd50},
    {2'd3, 16'd1000}, {2'd0, 16'd7}, {2'd1, 16'd9}};

  logic        ref_clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [3:0]  src_clks;
  logic [1:0]  src_sel = '0;
  logic [15:0] win_len = '0;
  logic [19:0] count;
  logic [9:0]  count_o;
  logic        overflow, done, overflow_o, done_o;
  int n_chk = 0, n_fail = 0;

  always #(TCLK/2) ref_clk = ~ref_clk;

  for (genvar g = 0; g < 4; g++) begin : g_src
    logic c = 1'b0;
    initial begin
      #0.7;
      forever #(PER[g] * 0.05) c = ~c;
    end
    assign src_clks[g] = c;
  end

  clk_freq_meter dut_i (.ref_clk(ref_clk), .rst_n(rst_n), .src_clks(src_clks),
    .src_sel(src_sel), .run(run), .win_len(win_len), .count(count),
    .overflow(overflow), .done(done));

  clk_freq_meter #(.CNT_W(10)) dut_o (.ref_clk(ref_clk), .rst_n(rst_n), .src_clks(src_clks),
    .src_sel(src_sel), .run(run), .win_len(win_len), .count(count_o),
    .overflow(overflow_o), .done(done_o));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_near(input string tag, input int sel, input int win, input longint c);
    longint d = c * PER[sel] - longint'(win) * TREF;
    if (d < 0) d = -d;
    check(d <= PER[sel], tag, c, (win * TREF) / PER[sel]);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!(done && done_o) && cyc < 20000) begin
      @(negedge ref_clk);
      cyc++;
    end
  endtask

  task automatic start(input int sel, input int win);
    @(negedge ref_clk);
    src_sel = 2'(sel);
    win_len = 16'(win);
    run = 1'b1;
  endtask

  task automatic stop_and_check;
    run = 1'b0;
    @(negedge ref_clk);
    check(done == 1'b0, "R6 done clears", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge ref_clk);
    check(count == 0, "R1 count in reset", count, 0);
    check(overflow == 0, "R1 overflow in reset", overflow, 0);
    check(done == 0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge ref_clk);

    for (int v = 0; v < NV; v++) begin
      int sel = int'(VECS[v][17:16]);
      int win = int'(VECS[v][15:0]);
      start(sel, win);
      wait_done(cyc);
      check_near("R2 count in band", sel, win, count);
      check(overflow == 0, "R2 no overflow", overflow, 0);
      check(cyc >= 24 + win, "R5 done latency", cyc, 24 + win);
      repeat (3) @(negedge ref_clk);
      check_near("R5 count holds", sel, win, count);
      stop_and_check();
    end

    // R4: zero window, settle edges must not count
    start(0, 0);
    wait_done(cyc);
    check(done == 1, "R4 zero window done", done, 1);
    check(count == 0, "R4 no settle edges", count, 0);
    stop_and_check();

    // R3: narrow instance saturates
    start(0, 500);
    wait_done(cyc);
    check(count_o == 10'h3FF, "R3 saturated count", count_o, 1023);
    check(overflow_o == 1, "R3 overflow flag", overflow_o, 1);
    check_near("R2 wide instance", 0, 500, count);
    stop_and_check();

    // R6: new start clears count and overflow
    start(0, 100);
    @(negedge ref_clk);
    check(count_o == 0, "R6 count cleared at start", count_o, 0);
    check(overflow_o == 0, "R6 overflow cleared at start", overflow_o, 0);
    wait_done(cyc);
    check_near("R6 narrow after overflow", 0, 100, longint'(count_o));
    check(overflow_o == 0, "R6 overflow stays clear", overflow_o, 0);
    stop_and_check();

    // R7: select change mid-run ignored
    start(3, 200);
    repeat (10) @(negedge ref_clk);
    src_sel = 2'd0;
    wait_done(cyc);
    check_near("R7 select frozen", 3, 200, count);
    stop_and_check();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule